// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a watchdog that counts down on a slow tick enable, divided by a selectable power-of-two prescaler. Software controls it through a five-entry register set on a simple write/read bus. Commands are 16-bit key values written to the key register. One key starts the counter. One key refreshes it. One key opens the three configuration registers for writing. Any other key closes them again.

Once started, the counter loads the active reload value and steps down by one every prescaled period. A step taken while the counter is already zero emits a one-cycle reset request, reloads the counter, and counting continues. When the window value is not all ones, a refresh that arrives while the counter is above the window is treated as a fault and also raises the reset request.

Each configuration write enters a shadow register first and takes effect only after a fixed number of ticks. A status flag shows that a transfer is pending, which models the delay of crossing into a slow clock domain.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, reading address 1 (prescale, bits [2:0]) returns 0, address 2 (reload) and address 3 (window) return 0xFFF, address 4 (status) returns 0, and address 0 (key) returns 0. `wdog_count` is 0xFFF, and both `wdog_running` and `wdog_rst_req` are low.
- R2: A write to addresses 1 to 3 is accepted only while the most recent key written was 0x5555. Any other key re-locks the registers, and a write made while locked leaves the readback and status unchanged.
- R3: An accepted write sets a status flag in the same cycle: bit 0 for prescale, bit 1 for reload, bit 2 for window. The flag stays set for SYNC_TICKS ticks counted after the write, and the readback shows the written value at once.
- R4: While a flag is set, the counter keeps using the previous value of that register. The new value is used once the flag has cleared.
- R5: Prescale codes 0 to 6 divide the tick by 4, 8, 16, 32, 64, 128 and 256. Code 7 also divides by 256.
- R6: After a start key (0xCCCC) or a refresh key (0xAAAA), the reset request rises on exactly the (reload+1)×divisor-th tick. Ticks at the command edge itself are not counted.
- R7: When the window is not 0xFFF, a refresh while the counter is greater than the window raises the reset request in the next cycle. A refresh while the counter equals the window does not.
- R8: The reset request lasts one cycle. The counter then holds the reload value and the next request follows after the same number of ticks.
- R9: Before the start key, the counter does not move and refresh keys have no effect. After the start key, no key write stops it.
- R10: A legal refresh on the same edge as the expiry step wins: no reset request is raised and the counter reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow tick enable, one cycle per tick |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address: 0 key, 1 prescale, 2 reload, 3 window, 4 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| wdog_rst_req | output | 1 | One-cycle reset request |
| wdog_count | output | CNT_W | Current counter value |
| wdog_running | output | 1 | Counter has been started |

## Verification
The sharpest interaction is a refresh key arriving on the very edge where the prescaler completes a period with the counter at zero. Both the reload path and the expiry path want the counter on that edge. The bench holds the tick high on every cycle with a reload of zero and prescale code 0, so expiry lands exactly four edges after the start key. A first run confirms that the request appears on that edge. A second run places the refresh on that same edge and expects no request and a counter of zero. Window boundaries are judged the same way: the bench refreshes when the counter equals the window (legal) and when it is one above it (fault).

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int KEY_W  = 16;
    localparam int PRE_W  = 3;
    localparam int PDIV_W = 8;

    localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

    typedef enum logic [2:0] {
        ADR_KEY  = 3'd0,
        ADR_PRE  = 3'd1,
        ADR_RLD  = 3'd2,
        ADR_WIN  = 3'd3,
        ADR_STAT = 3'd4
    } wd_addr_e;

    typedef struct packed {
        logic start;
        logic refresh;
    } wd_cmd_t;

    // Low-bit mask of the free-running prescale counter; all ones marks a period end.
    function automatic logic [PDIV_W-1:0] pre_mask(input logic [PRE_W-1:0] code);
        logic [3:0] sh;
        sh = (code == 3'd7) ? 4'd8 : ({1'b0, code} + 4'd2);
        return PDIV_W'((9'd1 << sh) - 9'd1);
    endfunction

endpackage

// File: rtl/wdog_key_dec.sv
module wdog_key_dec
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    output wd_cmd_t          cmd,
    output logic             unlocked
);

    always_comb begin
        cmd.start   = key_wr && (key_val == KEY_START);
        cmd.refresh = key_wr && (key_val == KEY_REFRESH);
    end

    always_ff @(posedge clk) begin
        if (rst)         unlocked <= 1'b0;
        else if (key_wr) unlocked <= (key_val == KEY_OPEN);
    end

endmodule

// File: rtl/wdog_cfg_slot.sv
module wdog_cfg_slot #(
    parameter int           W          = 12,
    parameter logic [W-1:0] RST_VAL    = '1,
    parameter int           SYNC_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         busy
);

    localparam int SC_W = $clog2(SYNC_TICKS + 1);
    logic [SC_W-1:0] sc;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= RST_VAL;
            active <= RST_VAL;
            busy   <= 1'b0;
            sc     <= '0;
        end else if (wr) begin
            shadow <= wdata;
            busy   <= 1'b1;
            sc     <= '0;
        end else if (busy && tick) begin
            if (sc == SC_W'(SYNC_TICKS - 1)) begin
                active <= shadow;
                busy   <= 1'b0;
                sc     <= '0;
            end else begin
                sc <= sc + 1'b1;
            end
        end
    end

    // R3: an accepted write raises the pending flag
    a_r3_flag_on_write: assert property (@(posedge clk) disable iff (rst)
        wr |=> busy);

    // R4: the value in use moves only when a pending transfer completes
    a_r4_active_on_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(active) |-> ($past(busy) && !busy));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  wd_cmd_t          cmd,
    input  logic [PRE_W-1:0] pre_code,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] window,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             rst_req
);

    logic [PDIV_W-1:0] pcnt;
    logic [PDIV_W-1:0] mask;
    logic              step;
    logic              viol;

    always_comb begin
        mask = pre_mask(pre_code);
        step = tick && ((pcnt & mask) == mask);
        viol = cmd.refresh && running && (window != '1) && (cnt > window);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '1;
            running <= 1'b0;
            pcnt    <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (!running) begin
                if (cmd.start) begin
                    running <= 1'b1;
                    cnt     <= reload;
                    pcnt    <= '0;
                end
            end else if (cmd.refresh) begin
                cnt     <= reload;
                pcnt    <= '0;
                rst_req <= viol;
            end else if (tick) begin
                pcnt <= pcnt + 1'b1;
                if (step) begin
                    if (cnt == '0) begin
                        cnt     <= reload;
                        rst_req <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            end
        end
    end

    // R9: once started the counter never stops
    a_r9_never_stops: assert property (@(posedge clk) disable iff (rst)
        running |=> running);

    // R9: the counter holds still until started
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!running && !$past(running)) |-> $stable(cnt));

    // R8: each request leaves the counter at the reload value
    a_r8_reload_on_req: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (cnt == $past(reload)));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int SYNC_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    output logic             wdog_rst_req,
    output logic [CNT_W-1:0] wdog_count,
    output logic             wdog_running
);

    wd_cmd_t          cmd;
    logic             unlocked;
    logic             key_wr;
    logic             pre_wr, rld_wr, win_wr;
    logic [PRE_W-1:0] pre_sh, pre_act;
    logic [CNT_W-1:0] rld_sh, rld_act, win_sh, win_act;
    logic             pre_busy, rld_busy, win_busy;

    always_comb begin
        key_wr = bus_we && (bus_addr == ADR_KEY);
        pre_wr = bus_we && unlocked && (bus_addr == ADR_PRE);
        rld_wr = bus_we && unlocked && (bus_addr == ADR_RLD);
        win_wr = bus_we && unlocked && (bus_addr == ADR_WIN);
    end

    wdog_key_dec u_key (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_val  (bus_wdata[KEY_W-1:0]),
        .cmd      (cmd),
        .unlocked (unlocked)
    );

    wdog_cfg_slot #(.W(PRE_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_pre (
        .clk(clk), .rst(rst), .tick(tick), .wr(pre_wr),
        .wdata(bus_wdata[PRE_W-1:0]),
        .shadow(pre_sh), .active(pre_act), .busy(pre_busy)
    );

    wdog_cfg_slot #(.W(CNT_W), .RST_VAL('1), .SYNC_TICKS(SYNC_TICKS)) u_rld (
        .clk(clk), .rst(rst), .tick(tick), .wr(rld_wr),
        .wdata(bus_wdata[CNT_W-1:0]),
        .shadow(rld_sh), .active(rld_act), .busy(rld_busy)
    );

    wdog_cfg_slot #(.W(CNT_W), .RST_VAL('1), .SYNC_TICKS(SYNC_TICKS)) u_win (
        .clk(clk), .rst(rst), .tick(tick), .wr(win_wr),
        .wdata(bus_wdata[CNT_W-1:0]),
        .shadow(win_sh), .active(win_act), .busy(win_busy)
    );

    wdog_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cmd      (cmd),
        .pre_code (pre_act),
        .reload   (rld_act),
        .window   (win_act),
        .cnt      (wdog_count),
        .running  (wdog_running),
        .rst_req  (wdog_rst_req)
    );

    always_comb begin
        case (bus_addr)
            ADR_PRE:  bus_rdata = 16'(pre_sh);
            ADR_RLD:  bus_rdata = 16'(rld_sh);
            ADR_WIN:  bus_rdata = 16'(win_sh);
            ADR_STAT: bus_rdata = 16'({win_busy, rld_busy, pre_busy});
            default:  bus_rdata = 16'h0000;
        endcase
    end

    // R2: a locked write leaves the reload shadow untouched
    a_r2_locked_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !unlocked && (bus_addr == ADR_RLD)) |=> $stable(rld_sh));

endmodule

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;

    localparam int CNT_W = 12;
    localparam int SYNC  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        tick_every = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        wdog_rst_req;
    logic [CNT_W-1:0] wdog_count;
    logic        wdog_running;

    int n_tests = 0;
    int n_fail  = 0;

    keyed_wdog #(.CNT_W(CNT_W), .SYNC_TICKS(SYNC)) u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdog_rst_req(wdog_rst_req),
        .wdog_count(wdog_count), .wdog_running(wdog_running)
    );

    always #10 clk = ~clk;

    always @(negedge clk) tick <= tick_every ? 1'b1 : ~tick;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic wait_ticks(input int n);
        int seen = 0;
        while (seen < n) begin
            @(posedge clk);
            if (tick) seen++;
        end
        @(negedge clk);
    endtask

    task automatic cfg(input logic [2:0] a, input logic [15:0] d);
        wr(3'd0, 16'h5555);
        wr(a, d);
        wait_ticks(SYNC + 1);
    endtask

    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (tick) n++;
            #1;
            if (wdog_rst_req) break;
        end
        @(negedge clk);
    endtask

    function automatic int divisor(input int code);
        return (code == 7) ? 256 : (4 << code);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int v, n, exp;
        bit seen;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(3'd1, v); check(v == 0, "R1 prescale", v, 0);
        rd(3'd2, v); check(v == 'hFFF, "R1 reload", v, 'hFFF);
        rd(3'd3, v); check(v == 'hFFF, "R1 window", v, 'hFFF);
        rd(3'd4, v); check(v == 0, "R1 status", v, 0);
        rd(3'd0, v); check(v == 0, "R1 key read", v, 0);
        check(wdog_count == 'hFFF, "R1 count", int'(wdog_count), 'hFFF);
        check(!wdog_running && !wdog_rst_req, "R1 running/req", int'({wdog_running, wdog_rst_req}), 0);

        // R9 idle: no counting, refresh ignored before start
        wr(3'd0, 16'hAAAA);
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (wdog_rst_req) seen = 1;
        end
        check(wdog_count == 'hFFF && !wdog_running, "R9 idle hold", int'(wdog_count), 'hFFF);
        check(!seen, "R9 no request before start", int'(seen), 0);

        // R2 locked writes ignored; a foreign key re-locks
        wr(3'd2, 16'd5);
        rd(3'd2, v); check(v == 'hFFF, "R2 locked reload", v, 'hFFF);
        rd(3'd4, v); check(v == 0, "R2 locked status", v, 0);
        wr(3'd0, 16'h5555);
        wr(3'd0, 16'h1234);
        wr(3'd2, 16'd5);
        rd(3'd2, v); check(v == 'hFFF, "R2 relocked reload", v, 'hFFF);

        // R3 flags and readback
        wr(3'd0, 16'h5555);
        wr(3'd1, 16'd2);
        rd(3'd4, v); check(v == 1, "R3 prescale flag", v, 1);
        rd(3'd1, v); check(v == 2, "R3 prescale readback", v, 2);
        wr(3'd2, 16'd3);
        wr(3'd3, 16'd7);
        rd(3'd4, v); check((v & 6) == 6, "R3 reload+window flags", v, 7);
        wait_ticks(SYNC - 1);
        rd(3'd4, v); check((v & 4) == 4, "R3 window flag still set", v, 4);
        wait_ticks(1);
        rd(3'd4, v); check(v == 0, "R3 flags cleared", v, 0);

        // R5 R6 R8 prescale sweep
        for (int code = 0; code < 8; code++) begin
            do_reset();
            cfg(3'd1, 16'(code));
            cfg(3'd2, 16'd2);
            wr(3'd0, 16'hCCCC);
            exp = 3 * divisor(code);
            measure(n);
            check(n == exp, $sformatf("R5 R6 code %0d timeout", code), n, exp);
            check(wdog_count == 2, "R8 counter reloaded", int'(wdog_count), 2);
            measure(n);
            check(n == exp, $sformatf("R8 second period code %0d", code), n, exp);
        end

        // R6 reload sweep at code 1
        for (int rl = 0; rl < 4; rl++) begin
            do_reset();
            cfg(3'd1, 16'd1);
            cfg(3'd2, 16'(rl));
            wr(3'd0, 16'hCCCC);
            measure(n);
            check(n == (rl + 1) * 8, $sformatf("R6 reload %0d", rl), n, (rl + 1) * 8);
        end

        // R4 old value in use while pending
        do_reset();
        cfg(3'd2, 16'd2);
        wr(3'd0, 16'hCCCC);
        wr(3'd0, 16'h5555);
        wr(3'd2, 16'd9);
        wr(3'd0, 16'hAAAA);
        check(wdog_count == 2, "R4 old reload used", int'(wdog_count), 2);
        rd(3'd4, v); check(v == 2, "R4 reload flag pending", v, 2);
        wait_ticks(SYNC);
        rd(3'd4, v); check(v == 0, "R4 flag cleared", v, 0);
        wr(3'd0, 16'hAAAA);
        check(wdog_count == 9, "R4 new reload used", int'(wdog_count), 9);

        // R7 window
        do_reset();
        cfg(3'd2, 16'd5);
        cfg(3'd3, 16'd1);
        wr(3'd0, 16'hCCCC);
        wr(3'd0, 16'hAAAA);
        check(wdog_rst_req == 1'b1, "R7 early refresh request", int'(wdog_rst_req), 1);
        check(wdog_count == 5, "R7 reload after fault", int'(wdog_count), 5);
        while (wdog_count != 2) @(negedge clk);
        wr(3'd0, 16'hAAAA);
        check(wdog_rst_req == 1'b1, "R7 window+1 is a fault", int'(wdog_rst_req), 1);
        while (wdog_count != 1) @(negedge clk);
        wr(3'd0, 16'hAAAA);
        check(wdog_rst_req == 1'b0, "R7 refresh at window is legal", int'(wdog_rst_req), 0);
        check(wdog_count == 5, "R7 legal reload", int'(wdog_count), 5);

        // R10 baseline: expiry lands four edges after start
        tick_every = 1'b1;
        do_reset();
        cfg(3'd2, 16'd0);
        wr(3'd0, 16'hCCCC);
        repeat (3) @(negedge clk);
        check(wdog_rst_req == 1'b0, "R10 baseline quiet", int'(wdog_rst_req), 0);
        @(posedge clk); #1;
        check(wdog_rst_req == 1'b1, "R10 baseline expiry", int'(wdog_rst_req), 1);
        @(negedge clk);
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h5555);
        check(wdog_running == 1'b1, "R9 cannot be stopped", int'(wdog_running), 1);

        // R10 refresh on the expiry edge wins
        do_reset();
        cfg(3'd2, 16'd0);
        wr(3'd0, 16'hCCCC);
        repeat (3) @(negedge clk);
        wr(3'd0, 16'hAAAA);
        check(wdog_rst_req == 1'b0, "R10 refresh beats expiry", int'(wdog_rst_req), 0);
        check(wdog_count == 0, "R10 counter reloaded", int'(wdog_count), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule